// File: doc/BRIEF.md
# Byte-Addressed Masked Merge Memory

This block is a small synchronous on-chip memory built for pixel uploads whose pixels can be narrower than a byte. A single write port accepts a byte address of any alignment together with a 32-bit data word, a 4-bit byte enable and a 32-bit per-bit merge mask. Enable bit k places data byte k at address+k. Within that byte, only the bits set in the matching mask byte are replaced. A 4-bit index can therefore be written into one half of a byte while the other half keeps its value. The merge happens while the memory array is updated, so two writes to the same byte on consecutive cycles both take effect without a forwarding path.

Three requesters share the write port: an upload engine, a rasterizer channel and a direct test path. Each one raises a busy flag to claim the port. The lowest-numbered busy requester is granted, and the other requesters see their ready held low. A byte-granular read port returns four consecutive bytes from any address so that the stored contents can be checked.

Top module: `bytemerge_mem`

## Requirements
- R1: A granted write with enable 4'b1111 and mask 0xFFFFFFFF stores data byte k (bits [8k+7:8k]) at address+k, for k = 0..3.
- R2: Enable bit k gates only byte address+k. Enable 4'b0011 stores bytes 0 and 1 only, and enable 4'b0001 stores byte 0 only; every other byte keeps its value.
- R3: Writes commit correctly at every byte alignment, including odd addresses, with no word-alignment restriction.
- R4: Inside an enabled byte, only the bits set in the mask byte change. Mask 0x0000000F changes bits [3:0] of the addressed byte, mask 0x000000F0 changes bits [7:4], and the other half is kept.
- R5: A write to one half of a byte followed on the very next cycle by a write to the other half of the same byte leaves both halves updated.
- R6: A granted write whose byte enable is zero, or whose mask is zero, leaves memory unchanged.
- R7: Byte addresses are taken modulo the depth. A multi-byte write or read that crosses the last byte continues at byte 0.
- R8: The read data on the cycle after rd_addr is presented holds byte rd_addr+k in bits [8k+7:8k]. A read of a byte that is written in the same cycle returns the value held before that write.
- R9: Requester 0 (upload) has the highest priority, then 1 (raster), then 2 (direct). Only the granted requester sees ready high, and a write from a requester that is not granted has no effect.
- R10: While reset is asserted, rd_data is zero, and no ready is high unless its requester is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_busy | input | NREQ (3) | Per-requester claim on the write port; index 0 has the highest priority |
| req_we | input | NREQ (3) | Per-requester write strobe |
| req_addr | input | NREQ x IW (3x8) | Per-requester byte address |
| req_data | input | NREQ x 32 | Per-requester data word; byte k goes to address+k |
| req_be | input | NREQ x 4 | Per-requester byte enable |
| req_mask | input | NREQ x 32 | Per-requester per-bit merge mask |
| req_ready | output | NREQ (3) | Grant; at most one bit is high |
| rd_addr | input | IW (8) | Read byte address |
| rd_data | output | 32 | Four bytes starting at rd_addr, one cycle later |

## Verification
A read and a write that target the same bytes can occur in the same cycle. The bench provokes this by presenting a write and a read to the same address on one clock edge. It then expects the pre-write bytes from that read and the merged bytes from a read on the following cycle. The bench also presents two writes on back-to-back cycles, one to each half of the same byte, and judges the result against a bench-side byte model. In the arbitration scenario, all three requesters write on the same edge, and the bench checks that only the winner's bytes changed.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  // Keep only the lowest set bit of a request vector.
  function automatic logic [31:0] first_set(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction
endpackage

// File: rtl/bmm_arbiter.sv
module bmm_arbiter
  import bmm_pkg::*;
#(
  parameter int NREQ = 3,
  parameter int IW   = 8
) (
  input  logic [NREQ-1:0]             req_busy,
  input  logic [NREQ-1:0]             req_we,
  input  logic [NREQ-1:0][IW-1:0]     req_addr,
  input  logic [NREQ-1:0][WORD_W-1:0] req_data,
  input  logic [NREQ-1:0][LANES-1:0]  req_be,
  input  logic [NREQ-1:0][WORD_W-1:0] req_mask,
  output logic [NREQ-1:0]             grant,
  output logic                        wr_commit,
  output logic [IW-1:0]               wr_addr,
  output logic [WORD_W-1:0]           wr_data,
  output logic [LANES-1:0]            wr_be,
  output logic [WORD_W-1:0]           wr_mask
);
  logic [31:0] first_c;

  always_comb begin
    first_c = first_set(32'(req_busy));
    grant   = first_c[NREQ-1:0];
  end

  // One-hot selection: an OR of ANDs, so no priority chain on the data path.
  always_comb begin
    wr_addr = '0;
    wr_data = '0;
    wr_be   = '0;
    wr_mask = '0;
    for (int i = 0; i < NREQ; i++) begin
      wr_addr = wr_addr | (req_addr[i] & {IW{grant[i]}});
      wr_data = wr_data | (req_data[i] & {WORD_W{grant[i]}});
      wr_be   = wr_be   | (req_be[i]   & {LANES{grant[i]}});
      wr_mask = wr_mask | (req_mask[i] & {WORD_W{grant[i]}});
    end
  end

  assign wr_commit = |(grant & req_we);
endmodule

// File: rtl/bmm_lanes.sv
module bmm_lanes
  import bmm_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic                          commit,
  input  logic [IW-1:0]                 addr,
  input  logic [WORD_W-1:0]             data,
  input  logic [LANES-1:0]              be,
  input  logic [WORD_W-1:0]             mask,
  output logic [LANES-1:0]              lane_en,
  output logic [LANES-1:0][IW-1:0]      lane_idx,
  output logic [LANES-1:0][BYTE_W-1:0]  lane_bits,
  output logic [LANES-1:0][BYTE_W-1:0]  lane_data
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_idx[k]  = addr + IW'(k);
    assign lane_bits[k] = mask[k*BYTE_W +: BYTE_W];
    assign lane_data[k] = data[k*BYTE_W +: BYTE_W];
    assign lane_en[k]   = commit & be[k] & (|mask[k*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/bmm_store.sv
module bmm_store
  import bmm_pkg::*;
#(
  parameter int DEPTH_BYTES = 256,
  parameter int IW          = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0]              lane_en,
  input  logic [LANES-1:0][IW-1:0]      lane_idx,
  input  logic [LANES-1:0][BYTE_W-1:0]  lane_bits,
  input  logic [LANES-1:0][BYTE_W-1:0]  lane_data,
  input  logic [IW-1:0]                 rd_idx,
  output logic [WORD_W-1:0]             rd_data
);
  logic [BYTE_W-1:0] mem [DEPTH_BYTES];
  logic [LANES-1:0][BYTE_W-1:0] merged_c;
  logic [WORD_W-1:0] rd_next_c;
  logic [WORD_W-1:0] rd_q;

  // Merge against the current array contents at the update itself.
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      merged_c[k] = (mem[lane_idx[k]] & ~lane_bits[k]) |
                    (lane_data[k] & lane_bits[k]);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (lane_en[k]) begin
        mem[lane_idx[k]] <= merged_c[k];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      rd_next_c[k*BYTE_W +: BYTE_W] = mem[rd_idx + IW'(k)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_next_c;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/bytemerge_mem.sv
module bytemerge_mem
  import bmm_pkg::*;
#(
  parameter int DEPTH_BYTES = 256,
  parameter int NREQ        = 3,
  localparam int IW         = $clog2(DEPTH_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREQ-1:0]             req_busy,
  input  logic [NREQ-1:0]             req_we,
  input  logic [NREQ-1:0][IW-1:0]     req_addr,
  input  logic [NREQ-1:0][31:0]       req_data,
  input  logic [NREQ-1:0][3:0]        req_be,
  input  logic [NREQ-1:0][31:0]       req_mask,
  output logic [NREQ-1:0]             req_ready,
  input  logic [IW-1:0]               rd_addr,
  output logic [31:0]                 rd_data
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  logic                         wr_commit;
  logic [IW-1:0]                wr_addr;
  logic [WORD_W-1:0]            wr_data;
  logic [LANES-1:0]             wr_be;
  logic [WORD_W-1:0]            wr_mask;
  logic [LANES-1:0]             lane_en;
  logic [LANES-1:0][IW-1:0]     lane_idx;
  logic [LANES-1:0][BYTE_W-1:0] lane_bits;
  logic [LANES-1:0][BYTE_W-1:0] lane_data;

  bmm_arbiter #(.NREQ(NREQ), .IW(IW)) u_arb (
    .req_busy (req_busy),
    .req_we   (req_we),
    .req_addr (req_addr),
    .req_data (req_data),
    .req_be   (req_be),
    .req_mask (req_mask),
    .grant    (req_ready),
    .wr_commit(wr_commit),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .wr_mask  (wr_mask)
  );

  bmm_lanes #(.IW(IW)) u_lanes (
    .commit   (wr_commit),
    .addr     (wr_addr),
    .data     (wr_data),
    .be       (wr_be),
    .mask     (wr_mask),
    .lane_en  (lane_en),
    .lane_idx (lane_idx),
    .lane_bits(lane_bits),
    .lane_data(lane_data)
  );

  bmm_store #(.DEPTH_BYTES(DEPTH_BYTES), .IW(IW)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .lane_en  (lane_en),
    .lane_idx (lane_idx),
    .lane_bits(lane_bits),
    .lane_data(lane_data),
    .rd_idx   (rd_addr),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/bmm_chk.sv
module bmm_chk #(
  parameter int NREQ = 3,
  parameter int IW   = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NREQ-1:0]         req_busy,
  input logic [NREQ-1:0]         req_we,
  input logic [NREQ-1:0][3:0]    req_be,
  input logic [NREQ-1:0][31:0]   req_mask,
  input logic [NREQ-1:0]         req_ready,
  input logic [IW-1:0]           rd_addr,
  input logic [31:0]             rd_data,
  input logic [3:0]              lane_en
);
  logic [2:0] age_q;
  logic       rd_primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 3'd7) begin
      age_q <= age_q + 3'd1;
    end
  end
  assign rd_primed = (age_q == 3'd7);

  // R9
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R10
  ready_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_busy) == '0);

  // R9
  commit_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en != 4'd0) |-> ((req_ready & req_we) != '0));

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    if (i > 0) begin : g_prio
      // R9
      priority_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready[i] |-> (req_busy[i-1:0] == '0));
    end
    // R1
    full_word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[i] && req_we[i] && req_be[i] == 4'hF && req_mask[i] == 32'hFFFF_FFFF)
        |-> (lane_en == 4'hF));
    // R6
    null_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready[i] && (req_be[i] == 4'd0 || req_mask[i] == 32'd0)) |-> (lane_en == 4'd0));
  end

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_primed && $past(rd_addr) == $past(rd_addr, 2) && $past(lane_en, 2) == 4'd0)
      |-> $stable(rd_data));
endmodule

bind bytemerge_mem bmm_chk #(.NREQ(NREQ), .IW(IW)) u_bmm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_busy (req_busy),
  .req_we   (req_we),
  .req_be   (req_be),
  .req_mask (req_mask),
  .req_ready(req_ready),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .lane_en  (lane_en)
);

// File: tb/test_bytemerge_mem.sv
`timescale 1ns/1ps
module test_bytemerge_mem;
  localparam int DEPTH = 256;
  localparam int NREQ  = 3;
  localparam int IW    = 8;

  logic                      clk;
  logic                      rst_n;
  logic [NREQ-1:0]           req_busy;
  logic [NREQ-1:0]           req_we;
  logic [NREQ-1:0][IW-1:0]   req_addr;
  logic [NREQ-1:0][31:0]     req_data;
  logic [NREQ-1:0][3:0]      req_be;
  logic [NREQ-1:0][31:0]     req_mask;
  logic [NREQ-1:0]           req_ready;
  logic [IW-1:0]             rd_addr;
  logic [31:0]               rd_data;

  int n_chk;
  int n_bad;
  logic [7:0] model [DEPTH];

  bytemerge_mem #(.DEPTH_BYTES(DEPTH), .NREQ(NREQ)) i_bytemerge_mem (
    .clk(clk), .rst_n(rst_n), .req_busy(req_busy), .req_we(req_we),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .req_mask(req_mask), .req_ready(req_ready), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(input int a);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[k*8 +: 8] = model[(a + k) % DEPTH];
    return w;
  endfunction

  task automatic model_write(input int a, input logic [31:0] d,
                             input logic [3:0] be, input logic [31:0] m);
    for (int k = 0; k < 4; k++) begin
      if (be[k]) begin
        model[(a + k) % DEPTH] = (model[(a + k) % DEPTH] & ~m[k*8 +: 8]) |
                                 (d[k*8 +: 8] & m[k*8 +: 8]);
      end
    end
  endtask

  // Drive one requester's write fields; caller controls timing.
  task automatic set_req(input int r, input int a, input logic [31:0] d,
                         input logic [3:0] be, input logic [31:0] m);
    req_busy[r] = 1'b1;
    req_we[r]   = 1'b1;
    req_addr[r] = IW'(a);
    req_data[r] = d;
    req_be[r]   = be;
    req_mask[r] = m;
  endtask

  task automatic idle_all();
    req_busy = '0;
    req_we   = '0;
  endtask

  task automatic write1(input int r, input int a, input logic [31:0] d,
                        input logic [3:0] be, input logic [31:0] m);
    @(negedge clk);
    set_req(r, a, d, be, m);
    model_write(a, d, be, m);
    @(negedge clk);
    idle_all();
  endtask

  task automatic check_read(input int a, input string tag);
    @(negedge clk);
    rd_addr = IW'(a);
    @(negedge clk);
    check(tag, rd_data, model_word(a));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_all();
    req_addr = '0; req_data = '0; req_be = '0; req_mask = '0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    check("R10 rd_data in reset", rd_data, 32'd0);
    check("R10 ready in reset", 32'(req_ready), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH / 4; i++) begin
      logic [31:0] w;
      for (int k = 0; k < 4; k++) w[k*8 +: 8] = 8'((4*i + k) * 37 + 5);
      write1(2, 4*i, w, 4'hF, 32'hFFFF_FFFF);
    end
    check_read(0, "R1 fill word 0");
    check_read(124, "R1 fill word 124");
  endtask

  task automatic t_full_word();
    write1(2, 40, 32'hA1B2_C3D4, 4'hF, 32'hFFFF_FFFF);
    check_read(40, "R1 full word");
    check_read(38, "R1 neighbours");
    check_read(42, "R1 upper neighbours");
  endtask

  task automatic t_partial_be();
    write1(1, 60, 32'h1122_3344, 4'b0011, 32'hFFFF_FFFF);
    check_read(58, "R2 be 0011");
    check_read(62, "R2 be 0011 untouched");
    write1(1, 70, 32'h5566_7788, 4'b0001, 32'hFFFF_FFFF);
    check_read(69, "R2 be 0001");
  endtask

  task automatic t_unaligned();
    write1(0, 81, 32'hDEAD_BEEF, 4'hF, 32'hFFFF_FFFF);
    check_read(80, "R3 odd addr word");
    check_read(84, "R3 odd addr tail");
    write1(0, 99, 32'h0000_005A, 4'b0001, 32'hFFFF_FFFF);
    check_read(99, "R3 odd byte");
    write1(0, 102, 32'h0000_00C3, 4'b0001, 32'hFFFF_FFFF);
    check_read(101, "R3 addr mod 4 = 2");
  endtask

  task automatic t_nibble();
    write1(2, 110, 32'h0000_0007, 4'b0001, 32'h0000_000F);
    check_read(110, "R4 low nibble");
    write1(2, 113, 32'h0000_0090, 4'b0001, 32'h0000_00F0);
    check_read(113, "R4 high nibble");
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    set_req(2, 131, 32'h0000_0003, 4'b0001, 32'h0000_000F);
    model_write(131, 32'h0000_0003, 4'b0001, 32'h0000_000F);
    @(negedge clk);
    set_req(2, 131, 32'h0000_00E0, 4'b0001, 32'h0000_00F0);
    model_write(131, 32'h0000_00E0, 4'b0001, 32'h0000_00F0);
    @(negedge clk);
    idle_all();
    check_read(131, "R5 both nibbles");
    check("R5 exact byte", {24'd0, model[131]}, 32'h0000_00E3);
  endtask

  task automatic t_no_effect();
    write1(2, 150, 32'hFFFF_FFFF, 4'b0000, 32'hFFFF_FFFF);
    check_read(150, "R6 zero be");
    write1(2, 150, 32'h0000_0000, 4'hF, 32'h0000_0000);
    check_read(150, "R6 zero mask");
  endtask

  task automatic t_wrap();
    write1(2, 254, 32'h4433_2211, 4'hF, 32'hFFFF_FFFF);
    check_read(254, "R7 wrap write and read");
    check_read(0, "R7 low bytes after wrap");
  endtask

  task automatic t_read_collide();
    logic [31:0] old;
    old = model_word(170);
    @(negedge clk);
    set_req(2, 170, 32'h9988_7766, 4'hF, 32'hFFFF_FFFF);
    rd_addr = IW'(170);
    model_write(170, 32'h9988_7766, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk);
    idle_all();
    check("R8 same-cycle read returns old", rd_data, old);
    @(negedge clk);
    check("R8 next read returns new", rd_data, model_word(170));
  endtask

  task automatic t_arbiter();
    @(negedge clk);
    set_req(0, 190, 32'h0101_0101, 4'hF, 32'hFFFF_FFFF);
    set_req(1, 200, 32'h0202_0202, 4'hF, 32'hFFFF_FFFF);
    set_req(2, 210, 32'h0303_0303, 4'hF, 32'hFFFF_FFFF);
    #1;
    check("R9 upload wins", 32'(req_ready), 32'b001);
    model_write(190, 32'h0101_0101, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk);
    req_busy[0] = 1'b0; req_we[0] = 1'b0;
    #1;
    check("R9 raster next", 32'(req_ready), 32'b010);
    model_write(200, 32'h0202_0202, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk);
    req_busy[1] = 1'b0; req_we[1] = 1'b0; req_we[2] = 1'b0;
    #1;
    check("R9 direct last", 32'(req_ready), 32'b100);
    @(negedge clk);
    idle_all();
    #1;
    check("R9 none busy", 32'(req_ready), 32'b000);
    check_read(190, "R9 upload data");
    check_read(200, "R9 raster data");
    check_read(210, "R9 direct held off");
  endtask

  task automatic run_all();
    t_reset();
    t_fill();
    t_full_word();
    t_partial_be();
    t_unaligned();
    t_nibble();
    t_back_to_back();
    t_no_effect();
    t_wrap();
    t_read_collide();
    t_arbiter();
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule